// File: doc/BRIEF.md
# Aliased Set/Clear Enable Register

This block is an APB3 slave that holds one small enable vector, such as the enable bits for a group of clock gates. Software sees the same storage at three word addresses. One address sets bits, one clears bits, and one is read-only. There is a single physical register behind all three addresses. Because of this, a driver can change individual enables with one write and needs no read-modify-write sequence.

The enable vector drives a parallel output straight from its flip-flops. Reads of the three mapped words return the current vector. A read of any other word inside the slave's window completes normally and returns a pattern set by a parameter. That pattern defaults to zero. The slave never inserts wait states and never signals an error.

Read data is registered: it is captured on the clock edge that ends the setup phase, so it is stable for the whole access phase. Writes take effect on the edge that ends the access phase.

Top module: `alias_enable_reg`

## Requirements
- R1: After a synchronous active-high reset, `en_out` is 0 and `prdata` is 0.
- R2: A write to byte offset 0x0 sets each enable bit whose matching `pwdata[3:0]` bit is 1. All other bits keep their value.
- R3: A write to byte offset 0x4 clears each enable bit whose matching `pwdata[3:0]` bit is 1. All other bits keep their value.
- R4: A read at offset 0x0, 0x4 or 0x8 returns the enable vector in `prdata[3:0]`, with zeros in bits 31:4.
- R5: A write to offset 0x8 or to an unmapped word leaves the enable vector unchanged.
- R6: A read of an unmapped word returns the parameter `RSVD_READ_VALUE`, with `pslverr` at 0.
- R7: `pready` is always 1 and `pslverr` is always 0, so every transfer ends in its access phase.
- R8: Address bits 1:0 take no part in decoding. For example, address 0x6 selects the clear view.
- R9: If reset is asserted on the same edge as a write access, reset wins and the enable vector becomes 0.
- R10: A change made through any view shows on `en_out` and on all read views from the very next transfer. This holds for a read whose setup phase immediately follows the write's access phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | 16 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, registered |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| en_out | output | 4 | Enable vector from the shared register |

## Verification
Two things can land on the same clock edge. The first pair is a write's access phase and a reset; the bench raises reset in the same cycle as the access phase of a set write and expects the vector to be zero afterwards. The second case is a read that follows a write with no idle cycle: the write's update and the next transfer's setup edge are adjacent. The bench issues a set or clear and then immediately reads a different view. It expects the new value, and its cycle-by-cycle model is compared against `en_out` and `prdata` on every falling edge.

// File: rtl/alias_reg_pkg.sv
package alias_reg_pkg;

  // Number of mapped views; view v lives at word index v past the base.
  localparam int NUM_VIEWS = 3;

  typedef enum int {
    VIEW_SET = 0,
    VIEW_CLR = 1,
    VIEW_RO  = 2
  } view_e;

endpackage

// File: rtl/alias_reg_decode.sv
module alias_reg_decode
  import alias_reg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 0
) (
  input  logic [ADDR_W-1:0]    paddr,
  output logic [NUM_VIEWS-1:0] hit,
  output logic                 any_hit
);

  localparam int WORD_W = ADDR_W - 2;

  logic [ADDR_W-1:0] rel;
  logic [WORD_W-1:0] word;

  assign rel  = paddr - ADDR_W'(BASE_ADDR);
  assign word = rel[ADDR_W-1:2];

  generate
    for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
      assign hit[v] = (word == WORD_W'(v));
    end
  endgenerate

  assign any_hit = |hit;

endmodule

// File: rtl/alias_reg_store.sv
module alias_reg_store #(
  parameter int EN_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_set,
  input  logic            wr_clr,
  input  logic [EN_W-1:0] wmask,
  output logic [EN_W-1:0] en_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_set) begin
      en_q <= en_q | wmask;
    end else if (wr_clr) begin
      en_q <= en_q & ~wmask;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_q == '0)); // R1

  AST_SET_BITS_RISE: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((en_q & $past(wmask)) == $past(wmask))); // R2

  AST_CLR_BITS_FALL: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((en_q & $past(wmask)) == '0)); // R3

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_set || wr_clr) |=> $stable(en_q)); // R5

endmodule

// File: rtl/alias_reg_rdmux.sv
module alias_reg_rdmux
  import alias_reg_pkg::*;
#(
  parameter int                  DATA_W          = 32,
  parameter int                  EN_W            = 4,
  parameter logic [DATA_W-1:0]   RSVD_READ_VALUE = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_cap,
  input  logic                 any_hit,
  input  logic [EN_W-1:0]      en,
  output logic [DATA_W-1:0]    rdata_q
);

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (any_hit) rd_d[EN_W-1:0] = en;
    else         rd_d = RSVD_READ_VALUE;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_cap) rdata_q <= rd_d;
  end

  AST_VIEW_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_cap && any_hit) |=> (rdata_q[EN_W-1:0] == $past(en))); // R4

  AST_RSVD_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_cap && !any_hit) |=> (rdata_q == RSVD_READ_VALUE)); // R6

endmodule

// File: rtl/alias_enable_reg.sv
module alias_enable_reg
  import alias_reg_pkg::*;
#(
  parameter int                ADDR_W          = 16,
  parameter int                DATA_W          = 32,
  parameter int                EN_W            = 4,
  parameter int                BASE_ADDR       = 0,
  parameter logic [DATA_W-1:0] RSVD_READ_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [EN_W-1:0]   en_out
);

  logic [NUM_VIEWS-1:0] hit;
  logic                 any_hit;
  logic                 wr_acc;
  logic                 rd_setup;
  logic                 wr_set;
  logic                 wr_clr;
  logic [EN_W-1:0]      en_q;

  assign wr_acc   = psel && penable && pwrite;
  assign rd_setup = psel && !penable && !pwrite;
  assign wr_set   = wr_acc && hit[VIEW_SET];
  assign wr_clr   = wr_acc && hit[VIEW_CLR];

  alias_reg_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .paddr  (paddr),
    .hit    (hit),
    .any_hit(any_hit)
  );

  alias_reg_store #(
    .EN_W(EN_W)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_set(wr_set),
    .wr_clr(wr_clr),
    .wmask (pwdata[EN_W-1:0]),
    .en_q  (en_q)
  );

  alias_reg_rdmux #(
    .DATA_W         (DATA_W),
    .EN_W           (EN_W),
    .RSVD_READ_VALUE(RSVD_READ_VALUE)
  ) u_rdmux (
    .clk    (clk),
    .rst    (rst),
    .rd_cap (rd_setup),
    .any_hit(any_hit),
    .en     (en_q),
    .rdata_q(prdata)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign en_out  = en_q;

  AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && !hit[VIEW_SET] && !hit[VIEW_CLR]) |=> $stable(en_out)); // R5

endmodule

// File: tb/sim_alias_enable_reg.sv
module sim_alias_enable_reg;

  localparam logic [31:0] RSV = 32'h0000EF00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [3:0]  en_out;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  alias_enable_reg #(.RSVD_READ_VALUE(RSV)) u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .en_out(en_out)
  );

  // Behavioural reference model
  int m_en = 0;
  int m_rd = 0;
  always @(posedge clk) begin
    int w;
    w = int'(paddr) / 4;
    if (rst) begin
      m_en <= 0;
      m_rd <= 0;
    end else begin
      if (psel && penable && pwrite) begin
        if (w == 0) m_en <= m_en | int'(pwdata % 16);
        else if (w == 1) m_en <= m_en - (m_en & int'(pwdata % 16));
      end
      if (psel && !penable && !pwrite)
        m_rd <= (w <= 2) ? m_en : int'(RSV);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    check({phase, " en_out"}, {28'b0, en_out}, 32'(m_en));
    check({phase, " prdata"}, prdata, 32'(m_rd));
    check("R7 pready", {31'b0, pready}, 32'd1);
    check("R7 pslverr", {31'b0, pslverr}, 32'd0);
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 5000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<5000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic apb_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic apb_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  logic [31:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset en_out", {28'b0, en_out}, 32'h0);
    check("R1 reset prdata", prdata, 32'h0);

    phase = "R2";
    apb_write(16'h0000, 32'h5);
    @(negedge clk);
    check("R2 set 0101", {28'b0, en_out}, 32'h5);
    apb_write(16'h0000, 32'hFFFF_FFF0);
    @(negedge clk);
    check("R2 set with zero mask", {28'b0, en_out}, 32'h5);

    phase = "R4";
    apb_read(16'h0008, rd); check("R4 ro view", rd, 32'h5);
    apb_read(16'h0000, rd); check("R4 set view", rd, 32'h5);
    apb_read(16'h0004, rd); check("R4 clr view", rd, 32'h5);

    phase = "R3";
    apb_write(16'h0004, 32'h1);
    @(negedge clk);
    check("R3 clear bit0", {28'b0, en_out}, 32'h4);

    phase = "R5";
    apb_write(16'h0008, 32'hF);
    @(negedge clk);
    check("R5 ro write inert", {28'b0, en_out}, 32'h4);
    apb_write(16'h0010, 32'hF);
    apb_read(16'h0008, rd);
    check("R5 reserved write inert", rd, 32'h4);

    phase = "R6";
    apb_read(16'h000C, rd); check("R6 reserved 0xC", rd, RSV);
    apb_read(16'h003C, rd); check("R6 reserved 0x3C", rd, RSV);

    phase = "R8";
    apb_write(16'h0002, 32'h3);
    apb_write(16'h0006, 32'h4);
    apb_read(16'h000B, rd); check("R8 low bits ignored", rd, 32'h3);

    // R10: write immediately followed by a read of another view
    phase = "R10";
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = 16'h0000; pwdata = 32'h8;
    @(negedge clk); penable = 1;
    @(negedge clk); penable = 0; pwrite = 0; paddr = 16'h0008;
    @(negedge clk); penable = 1;
    #1 check("R10 back-to-back set then read", prdata, 32'hB);
    @(negedge clk); penable = 0; pwrite = 1; paddr = 16'h0004; pwdata = 32'h2;
    @(negedge clk); penable = 1;
    @(negedge clk); penable = 0; pwrite = 0; paddr = 16'h0000;
    @(negedge clk); penable = 1;
    #1 check("R10 back-to-back clear then read", prdata, 32'h9);
    @(negedge clk); psel = 0; penable = 0;

    // R9: reset on the same edge as a write access
    phase = "R9";
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = 16'h0000; pwdata = 32'hF;
    @(negedge clk); penable = 1; rst = 1;
    @(negedge clk); psel = 0; penable = 0; rst = 0;
    check("R9 reset beats write", {28'b0, en_out}, 32'h0);
    apb_read(16'h0008, rd); check("R9 read after collision", rd, 32'h0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule